// File: doc/BRIEF.md
# Completion Event Ring Writer

This block turns finished transfer descriptors of a DMA engine into completion records in a circular event ring held in memory. Each completion arrives on a valid/ready handshake with a 4-bit status code, 4-bit error information and the descriptor's end-of-block request flag. The block builds a 16-byte record and issues it as one beat on a simple memory write port, at the ring's current byte offset. Once memory accepts the beat, the block moves its write pointer forward by one record. If the descriptor asked for it, the block also raises a one-cycle end-of-block pulse.

Software learns how far the ring is filled by reading the write pointer at register offset 0x20. It hands back consumed space by writing its own read offset to the doorbell at register offset 0x400. The pointer wraps to zero at the programmed ring length. One record slot always stays empty, so a full ring can be told apart from an empty one. While the ring is full, the block stops accepting completions. Upstream logic takes the end-of-block flag from bit 16 of the descriptor configuration word. The low byte of that word holds the transfer type (3 for a memory copy), and bits 15:8 hold the channel index.

Top module: `cpl_event_ring`

## Requirements
- R1: After reset, the write pointer reads 0 at register offset 0x20, `cplReady` is high, and `memWrValid` and `eobPulse` are low.
- R2: A record is written at `memWrOffset`, which equals the write pointer before the record. Bits 31:28 of word 0 (`memWrData[31:0]`) carry the status code (1 = complete, 4 = error). Bits 27:24 carry the error info. Bits 23:0 of word 0 and words 1 to 3 (`memWrData[127:32]`) are zero.
- R3: The write pointer changes only in the cycle after a `memWrValid`/`memWrReady` handshake, and it then moves forward by 16.
- R4: When the advanced pointer would reach or pass `ringLenBytes`, it becomes 0. The pointer is always a multiple of 16 and is always below `ringLenBytes`.
- R5: When the write pointer advanced by one record (with wrap) would equal the read offset, the ring is full. `cplReady` is then low and no completion is taken.
- R6: A register write to offset 0x400 loads the read offset from `regWdata` at the next clock edge, and a full ring is released in the following cycle. A doorbell may share a cycle with a record handshake, and both take effect.
- R7: `eobPulse` is high for exactly the one cycle after a record's write handshake, and only when that completion's `cplEobReq` was set.
- R8: Records leave in the order their completions were accepted. While `memWrValid` waits for `memWrReady`, the offset and data hold steady and no further completion is accepted.
- R9: A register read at any offset other than 0x20 returns zero, and register writes do not change the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ringLenBytes | input | OFF_W | Ring length in bytes, a multiple of 16, at least 32 |
| cplValid | input | 1 | Completion offered |
| cplReady | output | 1 | Completion taken when high with cplValid |
| cplStatus | input | 4 | Status code of the completion |
| cplErrInfo | input | 4 | Error information of the completion |
| cplEobReq | input | 1 | Descriptor requested an end-of-block pulse |
| memWrValid | output | 1 | Record write request |
| memWrReady | input | 1 | Memory accepts the record |
| memWrOffset | output | OFF_W | Byte offset of the record in the ring |
| memWrData | output | 128 | Record contents, word 0 in bits 31:0 |
| eobPulse | output | 1 | End-of-block pulse |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register offset for read and write |
| regWdata | input | OFF_W | Register write data |
| regRdata | output | OFF_W | Register read data, combinational from regAddr |

## Verification
The two functions that can fall in the same clock edge are a record's write handshake and a software doorbell. The first moves the write pointer and the second moves the read offset, and together they decide whether the ring is full in the next cycle. The bench holds a record pending with memory ready low. It then raises ready and writes the doorbell at the same edge, choosing values that leave the ring exactly full afterwards. It expects the pointer to advance, the end-of-block pulse to appear and `cplReady` to drop. Random traffic also fires timeout doorbells while completions are offered, and a cycle-by-cycle model judges every cycle's ready, pointer and pulse.

// File: rtl/cpl_ring_pkg.sv
package cpl_ring_pkg;
  localparam int REG_AW    = 12;
  localparam int WORD_W    = 32;
  localparam int REC_WORDS = 4;
  localparam int REC_BYTES = 16;
  localparam int REC_W     = REC_WORDS * WORD_W;
  localparam int CODE_W    = 4;
  localparam logic [REG_AW-1:0] WPTR_ADDR = 12'h020;
  localparam logic [REG_AW-1:0] BELL_ADDR = 12'h400;

  typedef struct packed {
    logic take;    // completion accepted this cycle
    logic commit;  // record write accepted by memory this cycle
    logic bell;    // doorbell register written this cycle
  } ringCtl_t;
endpackage

// File: rtl/cpl_ring_ctrl.sv
module cpl_ring_ctrl
  import cpl_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cplValid,
  input  logic              memWrReady,
  input  logic              ringFull,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output logic              cplReady,
  output logic              memWrValid,
  output ringCtl_t          ctl
);
  typedef enum logic {S_IDLE, S_WRITE} state_t;
  state_t state, stateNext;

  always_comb begin
    cplReady   = (state == S_IDLE) && !ringFull;
    memWrValid = (state == S_WRITE);
    ctl.take   = cplValid && cplReady;
    ctl.commit = memWrValid && memWrReady;
    ctl.bell   = regWe && (regAddr == BELL_ADDR);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (ctl.take)   stateNext = S_WRITE;
      S_WRITE: if (ctl.commit) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/cpl_ring_dpath.sv
module cpl_ring_dpath
  import cpl_ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCtl_t          ctl,
  input  logic [CODE_W-1:0] cplStatus,
  input  logic [CODE_W-1:0] cplErrInfo,
  input  logic              cplEobReq,
  input  logic [OFF_W-1:0]  ringLenBytes,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [OFF_W-1:0]  regWdata,
  output logic              ringFull,
  output logic [OFF_W-1:0]  memWrOffset,
  output logic [REC_W-1:0]  memWrData,
  output logic              eobPulse,
  output logic [OFF_W-1:0]  regRdata,
  output logic [OFF_W-1:0]  wrPtr,
  output logic [OFF_W-1:0]  rdOff
);
  localparam int ZERO_LO = WORD_W - 2 * CODE_W;

  logic [CODE_W-1:0] recStatus, recInfo;
  logic              recEob;
  logic [OFF_W:0]    ptrSum;
  logic [OFF_W-1:0]  ptrNext;
  logic [WORD_W-1:0] word0;

  // Pointer advance by one record, wrapping at the ring length.
  always_comb begin
    ptrSum  = {1'b0, wrPtr} + (OFF_W+1)'(REC_BYTES);
    ptrNext = (ptrSum >= {1'b0, ringLenBytes}) ? '0 : ptrSum[OFF_W-1:0];
  end

  assign ringFull = (ptrNext == rdOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdOff     <= '0;
      recStatus <= '0;
      recInfo   <= '0;
      recEob    <= 1'b0;
      eobPulse  <= 1'b0;
    end else begin
      if (ctl.take) begin
        recStatus <= cplStatus;
        recInfo   <= cplErrInfo;
        recEob    <= cplEobReq;
      end
      if (ctl.commit) wrPtr <= ptrNext;
      if (ctl.bell)   rdOff <= regWdata;
      eobPulse <= ctl.commit && recEob;
    end
  end

  assign word0       = {recStatus, recInfo, ZERO_LO'(0)};
  assign memWrOffset = wrPtr;

  for (genvar w = 0; w < REC_WORDS; w++) begin : g_word
    if (w == 0) begin : g_head
      assign memWrData[w*WORD_W +: WORD_W] = word0;
    end else begin : g_pad
      assign memWrData[w*WORD_W +: WORD_W] = '0;
    end
  end

  assign regRdata = (regAddr == WPTR_ADDR) ? wrPtr : '0;
endmodule

// File: rtl/cpl_event_ring.sv
module cpl_event_ring
  import cpl_ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFF_W-1:0]  ringLenBytes,
  input  logic              cplValid,
  output logic              cplReady,
  input  logic [CODE_W-1:0] cplStatus,
  input  logic [CODE_W-1:0] cplErrInfo,
  input  logic              cplEobReq,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [OFF_W-1:0]  memWrOffset,
  output logic [REC_W-1:0]  memWrData,
  output logic              eobPulse,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [OFF_W-1:0]  regWdata,
  output logic [OFF_W-1:0]  regRdata
);
  ringCtl_t         ctl;
  logic             ringFull;
  logic [OFF_W-1:0] wrPtr, rdOff;

  cpl_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cplValid(cplValid), .memWrReady(memWrReady),
    .ringFull(ringFull), .regWe(regWe), .regAddr(regAddr),
    .cplReady(cplReady), .memWrValid(memWrValid), .ctl(ctl)
  );

  cpl_ring_dpath #(.OFF_W(OFF_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cplStatus(cplStatus),
    .cplErrInfo(cplErrInfo), .cplEobReq(cplEobReq), .ringLenBytes(ringLenBytes),
    .regAddr(regAddr), .regWdata(regWdata), .ringFull(ringFull),
    .memWrOffset(memWrOffset), .memWrData(memWrData), .eobPulse(eobPulse),
    .regRdata(regRdata), .wrPtr(wrPtr), .rdOff(rdOff)
  );
endmodule

// File: rtl/cpl_event_ring_chk.sv
module cpl_event_ring_chk
  import cpl_ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [OFF_W-1:0]  ringLenBytes,
  input logic              cplReady,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [OFF_W-1:0]  memWrOffset,
  input logic [REC_W-1:0]  memWrData,
  input logic              eobPulse,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [OFF_W-1:0]  regWdata,
  input logic [OFF_W-1:0]  wrPtr,
  input logic [OFF_W-1:0]  rdOff
);
  logic [OFF_W:0]   chkSum;
  logic [OFF_W-1:0] chkNext;
  assign chkSum  = {1'b0, wrPtr} + (OFF_W+1)'(REC_BYTES);
  assign chkNext = (chkSum >= {1'b0, ringLenBytes}) ? '0 : chkSum[OFF_W-1:0];

  // R3
  ptr_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrValid && memWrReady) |=> $stable(wrPtr));

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr < ringLenBytes) && (wrPtr[3:0] == 4'd0));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplReady |-> (chkNext != rdOff));

  // R6
  doorbell_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == BELL_ADDR) |=> (rdOff == $past(regWdata)));

  // R7
  eob_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    eobPulse |-> $past(memWrValid && memWrReady));

  // R8
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> memWrValid && $stable(memWrData) && $stable(memWrOffset));

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> !cplReady);
endmodule

bind cpl_event_ring cpl_event_ring_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .ringLenBytes(ringLenBytes), .cplReady(cplReady),
  .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrOffset(memWrOffset),
  .memWrData(memWrData), .eobPulse(eobPulse), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .wrPtr(wrPtr), .rdOff(rdOff)
);

// File: tb/cpl_event_ring_test.sv
`timescale 1ns/1ps
module cpl_event_ring_test;
  localparam int OFF_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [OFF_W-1:0]  ringLenBytes = 16'd64;
  logic              cplValid = 1'b0;
  logic              cplReady;
  logic [3:0]        cplStatus = '0;
  logic [3:0]        cplErrInfo = '0;
  logic              cplEobReq = 1'b0;
  logic              memWrValid;
  logic              memWrReady = 1'b0;
  logic [OFF_W-1:0]  memWrOffset;
  logic [127:0]      memWrData;
  logic              eobPulse;
  logic              regWe = 1'b0;
  logic [11:0]       regAddr = 12'h020;
  logic [OFF_W-1:0]  regWdata = '0;
  logic [OFF_W-1:0]  regRdata;

  cpl_event_ring #(.OFF_W(OFF_W)) uut (.*);

  always #2.5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  int readyMode = 0;  // 0 always ready, 1 random, 2 never, 3 manual
  logic [OFF_W-1:0] expWrPtr = '0;
  logic [OFF_W-1:0] expRdOff = '0;
  logic [8:0] expQ[$];  // {eob, status, info}
  bit pendEob = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OFF_W-1:0] advPtr(input logic [OFF_W-1:0] p);
    int s = int'(p) + 16;
    return (s >= int'(ringLenBytes)) ? '0 : OFF_W'(s);
  endfunction

  function automatic bit isFull(input logic [OFF_W-1:0] p, input logic [OFF_W-1:0] r);
    return advPtr(p) == r;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Memory responder
  initial forever begin
    @(negedge clk);
    case (readyMode)
      0: memWrReady = 1'b1;
      1: memWrReady = ($urandom % 3) != 0;
      2: memWrReady = 1'b0;
      default: ;
    endcase
  end

  // Cycle model and monitor
  task automatic monitorStep();
    logic [8:0] rec;
    check(regRdata == ((regAddr == 12'h020) ? expWrPtr : '0), "R9/R3 register read", regRdata,
          (regAddr == 12'h020) ? expWrPtr : 0);
    check(cplReady == (!memWrValid && !isFull(expWrPtr, expRdOff)), "R5 cplReady", cplReady,
          !memWrValid && !isFull(expWrPtr, expRdOff));
    check(memWrValid == (expQ.size() != 0), "R8 one record in flight", memWrValid, expQ.size() != 0);
    check(eobPulse == pendEob, "R7 eobPulse", eobPulse, pendEob);
    pendEob = 0;
    if (memWrValid && memWrReady && expQ.size() != 0) begin
      rec = expQ.pop_front();
      check(memWrOffset == expWrPtr, "R2 record offset", memWrOffset, expWrPtr);
      check(memWrData[31:0] == {rec[7:4], rec[3:0], 24'h0}, "R2 word0", memWrData[31:0],
            {rec[7:4], rec[3:0], 24'h0});
      check(memWrData[127:32] == '0, "R2 words 1-3 zero", memWrData[95:32], 0);
      pendEob = rec[8];
      expWrPtr = advPtr(expWrPtr);
    end
    if (cplValid && cplReady) expQ.push_back({cplEobReq, cplStatus, cplErrInfo});
    if (regWe && regAddr == 12'h400) expRdOff = regWdata;
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    if (rstN) monitorStep();
  end

  task automatic sendCpl(input logic [3:0] st, input logic [3:0] inf, input bit eob);
    bit done = 0;
    int waited = 0;
    @(negedge clk);
    cplValid = 1; cplStatus = st; cplErrInfo = inf; cplEobReq = eob;
    while (!done) begin
      #1;
      if (cplReady) done = 1;
      @(negedge clk);
      regWe = 0; regAddr = 12'h020;
      if (!done) begin
        waited++;
        if (waited >= 20) begin
          regWe = 1; regAddr = 12'h400; regWdata = expWrPtr; waited = 0;
        end
      end
    end
    cplValid = 0;
  endtask

  task automatic ringBell(input logic [OFF_W-1:0] v);
    @(negedge clk);
    regWe = 1; regAddr = 12'h400; regWdata = v;
    @(negedge clk);
    regWe = 0; regAddr = 12'h020;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1;
    // R1 during reset
    check(cplReady == 1, "R1 cplReady in reset", cplReady, 1);
    check(memWrValid == 0, "R1 memWrValid in reset", memWrValid, 0);
    rstN = 1;
    @(negedge clk); #1;
    check(regRdata == 0, "R1 write pointer after reset", regRdata, 0);
    check(eobPulse == 0, "R1 eobPulse after reset", eobPulse, 0);

    // Three records fill a 4-slot ring to its limit
    sendCpl(4'd1, 4'd0, 1);
    sendCpl(4'd4, 4'd9, 0);
    sendCpl(4'd1, 4'd3, 1);
    repeat (4) @(negedge clk);
    #1;
    check(regRdata == 16'd48, "R3 pointer after three records", regRdata, 48);

    // Full ring stalls a completion until the doorbell
    @(negedge clk);
    cplValid = 1; cplStatus = 4'd4; cplErrInfo = 4'd7; cplEobReq = 0;
    repeat (8) @(negedge clk);
    #1;
    check(cplReady == 0, "R5 stalled while full", cplReady, 0);
    check(regRdata == 16'd48, "R5 no record while full", regRdata, 48);
    @(negedge clk);
    regWe = 1; regAddr = 12'h400; regWdata = 16'd16;
    @(negedge clk);
    regWe = 0; regAddr = 12'h020;
    #1;
    check(cplReady == 1, "R6 doorbell releases stall", cplReady, 1);
    @(negedge clk);
    cplValid = 0;
    repeat (3) @(negedge clk);
    #1;
    check(regRdata == 16'd0, "R4 pointer wraps to zero", regRdata, 0);

    // Memory holds off: record waits, nothing else taken
    readyMode = 2;
    sendCpl(4'd1, 4'd5, 1);
    @(negedge clk);
    cplValid = 1; cplStatus = 4'd4; cplErrInfo = 4'd2; cplEobReq = 1;
    repeat (5) @(negedge clk);
    #1;
    check(memWrValid == 1, "R8 write held pending", memWrValid, 1);
    check(cplReady == 0, "R8 no accept while pending", cplReady, 0);
    @(negedge clk);
    cplValid = 0;

    // Write handshake and doorbell at the same edge: ring left exactly full
    readyMode = 3;
    @(negedge clk);
    memWrReady = 1; regWe = 1; regAddr = 12'h400; regWdata = 16'd32;
    @(negedge clk);
    memWrReady = 0; regWe = 0; regAddr = 12'h020;
    #1;
    check(regRdata == 16'd16, "R6 pointer advanced with concurrent doorbell", regRdata, 16);
    check(eobPulse == 1, "R7 pulse after concurrent write", eobPulse, 1);
    check(cplReady == 0, "R6 new read offset makes ring full", cplReady, 0);
    readyMode = 0;
    ringBell(16'd16);

    // No end-of-block request, no pulse
    sendCpl(4'd1, 4'd2, 0);
    repeat (3) @(negedge clk);

    // Constrained random traffic on a larger ring
    ringLenBytes = 16'd128;
    readyMode = 1;
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 20;
      if (op < 14) begin
        sendCpl((($urandom % 4) == 0) ? 4'd4 : 4'd1, 4'($urandom), 1'($urandom));
      end else if (op < 17) begin
        ringBell(expWrPtr);
      end else begin
        @(negedge clk);
        case ($urandom % 3)
          0: regAddr = 12'h010;
          1: regAddr = 12'h400;
          default: regAddr = 12'h024;
        endcase
        @(negedge clk);
        regAddr = 12'h020;
      end
    end
    readyMode = 0;
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R8 all records written", expQ.size(), 0);
    finish();
  end
endmodule